// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small 8-bit CPU core and turns up to sixteen peripheral request lines into a single vectored interrupt request. Each line is set up either as an event source, whose request is caught in a sticky flag, or as a level source, which requests only while its line is high and keeps no flag. A per-source enable mask and one global enable gate the requests. Among the gated requests the lowest index always wins.

The core tells the controller when it reaches an instruction boundary. Only then does the controller arbitrate. The result is offered as a valid/ready pair: `irq_req` is the valid and `irq_ack` is the ready. Once `irq_req` rises, both it and `irq_vec` hold steady until the core acknowledges, and no new arbitration starts. There is no further back-pressure: the core may hold off `irq_ack` for any number of cycles. Taking an interrupt clears the global enable. A return-from-interrupt sets it again, and then forces one full instruction before the next take.

Software reaches the flag, enable and source-type registers through a simple synchronous write port with a combinational read port.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` and `gie` are 0, and the registers at select 0 (flags), 1 (enables) and 2 (types) all read 0. Select 3 always reads 0.
- R2: A source whose type bit is 1 (event) sets its flag bit in any cycle its `src_i` line is high, even while its enable bit or the global enable is 0.
- R3: Writing select 0 clears each flag bit written as 1 and leaves each bit written as 0 unchanged. If a new event arrives for a source in the same cycle its flag is cleared, the flag stays set.
- R4: A source whose type bit is 0 (level) never shows a flag. It requests only while its line is high and enabled, so a level pulse that ends before its enable is set causes no interrupt.
- R5: Arbitration takes place only in a cycle with `instr_done` high, `gie` at 1 and some enabled request. `irq_req` rises in the next cycle, and `irq_vec` then carries the lowest pending index.
- R6: While `irq_req` is 1 and `irq_ack` is 0, `irq_req` stays 1 and `irq_vec` does not change.
- R7: Taking an interrupt clears `gie`. Acknowledging an event-type vector clears that source's flag.
- R8: `reti` sets `gie` in the next cycle. The first `instr_done` after a `reti` never starts an interrupt; the second one may.
- R9: `gie_clr` takes effect in its own cycle. No interrupt starts from an `instr_done` in the same cycle, and `gie_clr` overrides a simultaneous `gie_set`.
- R10: If software sets `gie` inside a handler after the acknowledge, a newly pending enabled source is taken at the next boundary, so handlers nest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Peripheral request lines |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 flags, 1 enables, 2 types |
| reg_wdata | input | N_SRC | Write data |
| reg_rdata | output | N_SRC | Read data for `reg_sel` |
| instr_done | input | 1 | Core is at an instruction boundary |
| irq_ack | input | 1 | Core accepts the offered vector (ready) |
| reti | input | 1 | Return-from-interrupt executed |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable at once |
| irq_req | output | 1 | Interrupt offered (valid) |
| irq_vec | output | $clog2(N_SRC) | Index of the offered source |
| gie | output | 1 | Current global enable |

## Verification
The bench aims at these corner cases:
- A clear-by-write that lands in the same cycle as a fresh event. A design that gives the write priority loses that event.
- The boundary right after a return-from-interrupt. A design without the one-instruction shadow takes an interrupt there.
- An `instr_done` that coincides with `gie_clr`. A design that applies the disable a cycle late takes an interrupt it should block.
- A vector held through several cycles without `irq_ack`, while a lower-priority level source rises. A design that re-arbitrates during that time changes `irq_vec` under the core.

Random type, enable and request mixes are checked against a lowest-set-bit model. That model also covers the flag-clear rule on acknowledge, which a design that wrongly clears level sources or non-winning flags would break.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_ENA  = 2'd1,
    SEL_KIND = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [N_SRC-1:0] wdata,
  input  logic [N_SRC-1:0] ack_clr,
  output logic [N_SRC-1:0] flag_q,
  output logic [N_SRC-1:0] ena_q,
  output logic [N_SRC-1:0] kind_q,
  output logic [N_SRC-1:0] pend
);
  import irq_pkg::*;

  logic wr_flag, wr_ena, wr_kind;
  assign wr_flag = wr_en && (reg_sel_e'(wr_sel) == SEL_FLAG);
  assign wr_ena  = wr_en && (reg_sel_e'(wr_sel) == SEL_ENA);
  assign wr_kind = wr_en && (reg_sel_e'(wr_sel) == SEL_KIND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      kind_q <= '0;
    end else begin
      if (wr_ena)  ena_q  <= wdata;
      if (wr_kind) kind_q <= wdata;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag_q[i] <= 1'b0;
      else if (!kind_q[i])
        flag_q[i] <= 1'b0;
      else if (src_i[i])
        flag_q[i] <= 1'b1;
      else if ((wr_flag && wdata[i]) || ack_clr[i])
        flag_q[i] <= 1'b0;
    end
    assign pend[i] = ena_q[i] && (kind_q[i] ? flag_q[i] : src_i[i]);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_done,
  input  logic             irq_ack,
  input  logic             reti,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             any,
  input  logic [IDX_W-1:0] idx,
  output logic             req_q,
  output logic [IDX_W-1:0] vec_q,
  output logic             gie_q,
  output logic             ack_fire
);
  logic hold_q;
  logic take;

  assign take = instr_done && gie_q && !gie_clr && !hold_q && !reti && !req_q && any;
  assign ack_fire = irq_ack && req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
      req_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (gie_clr || take)      gie_q <= 1'b0;
      else if (gie_set || reti) gie_q <= 1'b1;

      if (reti)            hold_q <= 1'b1;
      else if (instr_done) hold_q <= 1'b0;

      if (take) begin
        req_q <= 1'b1;
        vec_q <= idx;
      end else if (ack_fire) begin
        req_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_sel,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  input  logic             instr_done,
  input  logic             irq_ack,
  input  logic             reti,
  input  logic             gie_set,
  input  logic             gie_clr,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_vec,
  output logic             gie
);
  import irq_pkg::*;

  logic [N_SRC-1:0] flag_q, ena_q, kind_q, pend, ack_clr;
  logic             any, ack_fire;
  logic [IDX_W-1:0] win_idx;

  irq_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .wr_en(reg_wr_en), .wr_sel(reg_sel), .wdata(reg_wdata),
    .ack_clr(ack_clr), .flag_q(flag_q), .ena_q(ena_q),
    .kind_q(kind_q), .pend(pend)
  );

  irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .pend(pend), .any(any), .idx(win_idx)
  );

  irq_gate #(.IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done),
    .irq_ack(irq_ack), .reti(reti), .gie_set(gie_set),
    .gie_clr(gie_clr), .any(any), .idx(win_idx),
    .req_q(irq_req), .vec_q(irq_vec), .gie_q(gie), .ack_fire(ack_fire)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_clr
    assign ack_clr[i] = ack_fire && (irq_vec == IDX_W'(i));
  end

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_FLAG: reg_rdata = flag_q;
      SEL_ENA:  reg_rdata = ena_q;
      SEL_KIND: reg_rdata = kind_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_done,
  input logic             irq_ack,
  input logic             reti,
  input logic             gie_clr,
  input logic             irq_req,
  input logic [IDX_W-1:0] irq_vec,
  input logic             gie
);
  // R6: offered vector is held until accepted
  assert_hold_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

  // R5: a take only follows an instruction boundary
  assert_take_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(instr_done));

  // R7: a take leaves the global enable cleared
  assert_take_clears_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> !gie);

  // R8: return sets the global enable and blocks a take in its cycle
  assert_reti_sets_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !gie_clr) |=> gie);

  assert_reti_no_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_req) |=> !irq_req);

  // R9: disable in the same cycle blocks any take
  assert_clr_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_clr && !irq_req) |=> (!irq_req && !gie));
endmodule

bind vec_irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .irq_ack(irq_ack),
  .reti(reti), .gie_clr(gie_clr), .irq_req(irq_req), .irq_vec(irq_vec),
  .gie(gie)
);

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
  localparam int N = 16;
  localparam int W = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] lvl = '0, pulse = '0;
  logic [N-1:0] src_i;
  logic reg_wr_en = 0;
  logic [1:0] reg_sel = 0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic instr_done = 0, irq_ack = 0, reti = 0, gie_set = 0, gie_clr = 0;
  logic irq_req, gie;
  logic [W-1:0] irq_vec;
  int checks = 0, errors = 0;
  bit done = 0;

  assign src_i = lvl | pulse;
  always #2 clk = ~clk;

  vec_irq_ctrl #(.N_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr_en(reg_wr_en),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .instr_done(instr_done), .irq_ack(irq_ack), .reti(reti),
    .gie_set(gie_set), .gie_clr(gie_clr), .irq_req(irq_req),
    .irq_vec(irq_vec), .gie(gie)
  );

  function automatic int low_bit(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [N-1:0] d);
    reg_wr_en = 1; reg_sel = s; reg_wdata = d;
    step();
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [N-1:0] d);
    reg_sel = s; #0.5; d = reg_rdata;
  endtask

  task automatic fire(input logic [N-1:0] p);
    pulse = p; step(); pulse = '0;
  endtask

  task automatic core(input bit d, input bit a, input bit r, input bit s, input bit c);
    instr_done = d; irq_ack = a; reti = r; gie_set = s; gie_clr = c;
    step();
    instr_done = 0; irq_ack = 0; reti = 0; gie_set = 0; gie_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    void'($urandom(32'd41));
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    check("R1 irq_req", irq_req, 0);
    check("R1 gie", gie, 0);
    rd(0, d); check("R1 flags", d, 0);
    rd(1, d); check("R1 enables", d, 0);
    rd(2, d); check("R1 types", d, 0);
    rd(3, d); check("R1 sel3", d, 0);

    wr(2, 16'h00FF);
    fire(16'h0008);
    rd(0, d); check("R2 flag while masked", d, 16'h0008);
    wr(0, 16'h0000);
    rd(0, d); check("R3 write zero keeps", d, 16'h0008);
    wr(0, 16'h0008);
    rd(0, d); check("R3 write one clears", d, 16'h0000);
    pulse = 16'h0008; wr(0, 16'h0008); pulse = '0;
    rd(0, d); check("R3 event beats clear", d, 16'h0008);

    wr(1, 16'hFFFF);
    fire(16'h0020);
    core(0, 0, 0, 1, 0);
    check("R5 gie set", gie, 1);
    core(1, 0, 0, 0, 0);
    check("R5 req", irq_req, 1);
    check("R5 lowest vec", irq_vec, 3);
    check("R7 gie cleared", gie, 0);
    lvl = 16'h0200;
    repeat (3) step();
    check("R6 req held", irq_req, 1);
    check("R6 vec held", irq_vec, 3);
    core(0, 1, 0, 0, 0);
    check("R6 req drops on ack", irq_req, 0);
    rd(0, d); check("R7 ack clears flag", d, 16'h0020);

    core(0, 0, 1, 0, 0);
    check("R8 reti sets gie", gie, 1);
    core(1, 0, 0, 0, 0);
    check("R8 shadow boundary", irq_req, 0);
    core(1, 0, 0, 0, 0);
    check("R8 second boundary", irq_req, 1);
    check("R5 event 5 beats level 9", irq_vec, 5);
    core(0, 1, 0, 0, 0);
    core(0, 0, 0, 1, 0);
    core(1, 0, 0, 0, 0);
    check("R4 level take", irq_vec, 9);
    rd(0, d); check("R4 no flag for level", d, 0);
    core(0, 1, 0, 0, 0);
    lvl = '0;
    core(0, 0, 0, 1, 0);

    wr(1, 16'hFBFF);
    lvl = 16'h0400; step(); lvl = '0;
    wr(1, 16'hFFFF);
    core(1, 0, 0, 0, 0);
    check("R4 vanished level", irq_req, 0);

    core(0, 0, 0, 0, 1);
    fire(16'h0002);
    core(1, 0, 0, 0, 0);
    check("R5 no take with gie off", irq_req, 0);
    core(0, 0, 0, 1, 0);
    core(1, 0, 0, 0, 1);
    check("R9 clr same cycle", irq_req, 0);
    check("R9 gie off", gie, 0);
    core(0, 0, 0, 1, 1);
    check("R9 clr beats set", gie, 0);

    core(0, 0, 0, 1, 0);
    core(1, 0, 0, 0, 0);
    check("R10 outer vec", irq_vec, 1);
    core(0, 1, 0, 0, 0);
    core(0, 0, 0, 1, 0);
    fire(16'h0001);
    core(1, 0, 0, 0, 0);
    check("R10 nested req", irq_req, 1);
    check("R10 nested vec", irq_vec, 0);
    core(0, 1, 0, 0, 0);
    core(0, 0, 1, 0, 0);
    core(1, 0, 0, 0, 0);
    check("R8 shadow after nest", irq_req, 0);

    for (int it = 0; it < 60; it++) begin
      logic [N-1:0] ty, en, ev, lv, pend;
      int v;
      ty = N'($urandom()); en = N'($urandom());
      lv = N'($urandom()) & ~ty; ev = N'($urandom()) & ty;
      if (it % 7 == 0) en = '0;
      wr(0, '1);
      wr(2, ty); wr(1, en);
      lvl = lv;
      fire(ev);
      rd(0, d); check("R2 random flags", d, ev);
      core(0, 0, 0, 1, 0);
      pend = (ev | lv) & en;
      v = low_bit(pend);
      core(1, 0, 0, 0, 0);
      check("R5 random req", irq_req, (v >= 0) ? 1 : 0);
      if (v >= 0) begin
        check("R5 random vec", irq_vec, v);
        core(0, 1, 0, 0, 0);
        rd(0, d);
        check("R7 random flag clear", d, ty[v] ? (ev & ~(N'(1) << v)) : ev);
      end
      lvl = '0;
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule